// File: doc/BRIEF.md
# Vector Floating-Point Narrowing Converter

This block takes a 128-bit vector of IEEE 754 floating-point elements and converts every element to a format half as wide. A size select picks the conversion. One setting turns four single-precision lanes into four half-precision lanes. The other turns two double-precision lanes into two single-precision lanes. Either way the narrowed lanes are packed into a 64-bit result.

The 64-bit result is then merged into a 128-bit destination value. A half select sets the merge. In low mode the result fills the lower half and the upper half is cleared. In high mode the result fills the upper half and the lower half is copied from the prior destination value that the caller supplies.

Each lane is rounded under a 2-bit rounding-mode input. Every lane reports IEEE exception conditions, and these are ORed across the active lanes into one flag vector. That vector is meant to be accumulated by a status register outside the block.

One registered stage separates a valid strobe from its result. The result appears together with a done strobe and the flag pulse.

Top module: `fpn_narrow_vec`

## Requirements
- R1: With `size_sel`=0, source bits [32e+31:32e] (e=0..3), read as a single, become a half placed at result bits [16e+15:16e].
- R2: With `size_sel`=1, source bits [64e+63:64e] (e=0..1), read as a double, become a single placed at result bits [32e+31:32e].
- R3: With `half_sel`=0, `dst_out[63:0]` takes the result and `dst_out[127:64]` is zero.
- R4: With `half_sel`=1, `dst_out[127:64]` takes the result and `dst_out[63:0]` equals `dst_prev[63:0]`.
- R5: Rounding follows `rmode`: 00 nearest-even, 01 toward +infinity, 10 toward -infinity, 11 toward zero. Any discarded nonzero bits set the inexact flag.
- R6: A magnitude too large for the narrow format, before or after rounding, overflows. It yields infinity when the mode rounds away from zero for that sign, and the largest finite value of that sign otherwise. Overflow and inexact are both flagged.
- R7: Results below the normal range are denormalized and correctly rounded, including source subnormals. Underflow is flagged only when the value is tiny before rounding and also inexact.
- R8: A signaling NaN gives a quiet NaN that keeps the sign and the upper payload bits below the quiet bit, and it flags invalid. A quiet NaN gives a quiet NaN with truncated payload and no flag.
- R9: Infinities and zeros of either sign convert to the same class and sign with no flag.
- R10: `flags_out` bits are {invalid, overflow, underflow, inexact} from bit 3 down to bit 0. `done`, `dst_out` and `flags_out` update on the clock edge after the edge at which `in_valid` was sampled high. Without `in_valid`, `done` and `flags_out` are zero and `dst_out` holds.
- R11: After reset, `dst_out`, `flags_out` and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Starts one conversion |
| size_sel | input | 1 | 0: single to half, 1: double to single |
| half_sel | input | 1 | 0: write low half and clear high half, 1: write high half and keep low half |
| rmode | input | 2 | Rounding mode (encoding given in R5) |
| src_vec | input | 128 | Source vector |
| dst_prev | input | 128 | Prior destination value |
| dst_out | output | 128 | Merged destination value |
| flags_out | output | 4 | Exception flag pulse {inv, ovf, unf, nx} |
| done | output | 1 | Result valid strobe |

## Verification
Every result is due exactly one clock edge after the edge that samples `in_valid`. The bench therefore drives inputs on a falling edge, drops `in_valid` at the next falling edge, and samples `dst_out`, `flags_out` and `done` at that moment. Between those two falling edges only the capturing rising edge has occurred. One falling edge later the bench checks that the strobe and flags have gone back to zero and that the destination held, even with the inputs changed. Corner values include rounding ties, overflow that rounding itself causes, exact and inexact tiny results, and signaling NaNs. Their expected values are worked out by hand from the IEEE formats.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_POS  = 2'b01,
    RND_NEG  = 2'b10,
    RND_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic inv;
    logic ovf;
    logic unf;
    logic nx;
  } fpflags_t;

endpackage

// File: rtl/fpn_rst_sync.sv
module fpn_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];

endmodule

// File: rtl/fpn_lane_narrow.sv
module fpn_lane_narrow
  import fpn_pkg::*;
#(
  parameter int SE = 8,
  parameter int SM = 23,
  parameter int DE = 5,
  parameter int DM = 10
) (
  input  logic [SE+SM:0] src_i,
  input  rmode_e         rmode_i,
  output logic [DE+DM:0] res_o,
  output fpflags_t       flags_o
);

  localparam int SBIAS = (1 << (SE - 1)) - 1;
  localparam int DBIAS = (1 << (DE - 1)) - 1;
  localparam int DROP  = SM - DM;
  localparam int SHW   = $clog2(SM + 2) + 1;
  localparam int EW    = SE + 2;
  localparam logic signed [EW-1:0] EXP_TOP = EW'((1 << DE) - 1);
  localparam logic signed [EW-1:0] SH_CAP  = EW'(SM + 1);
  localparam logic signed [EW-1:0] ONE_S   = EW'(1);
  localparam logic signed [EW-1:0] BIAS_D  = EW'(DBIAS - SBIAS);

  logic                 sgn;
  logic [SE-1:0]        ex;
  logic [SM-1:0]        mt;
  logic signed [EW-1:0] de;
  logic signed [EW-1:0] neg;
  logic [SHW-1:0]       sh;
  logic [SM+1:0]        wv;
  logic [SM+1:0]        shifted;
  logic                 lost;
  logic [DM:0]          kept;
  logic                 grd;
  logic                 stk;
  logic                 inc;
  logic                 away;
  logic                 pre_ovf;
  logic [DE-1:0]        expf;
  logic [DE+DM:0]       mag;
  logic                 tiny;
  logic                 inexact;

  always_comb begin
    sgn = src_i[SE+SM];
    ex  = src_i[SE+SM-1:SM];
    mt  = src_i[SM-1:0];
    de  = $signed({2'b00, ex}) + BIAS_D;
    neg = ONE_S - de;

    // alignment shift: zero for normal targets, capped for deep underflow
    if (ex == '0)          sh = SHW'(SM + 1);
    else if (de >= ONE_S)  sh = '0;
    else if (neg > SH_CAP) sh = SHW'(SM + 1);
    else                   sh = neg[SHW-1:0];

    wv      = {1'b0, (ex != '0), mt};
    shifted = wv >> sh;
    lost    = |(wv & ~({(SM+2){1'b1}} << sh));
    kept    = shifted[SM:DROP];
    grd     = shifted[DROP-1];
    stk     = (|shifted[DROP-2:0]) | lost;
    inexact = grd | stk;
    tiny    = (sh != '0);

    unique case (rmode_i)
      RND_NEAR: inc = grd & (stk | kept[0]);
      RND_POS:  inc = ~sgn & inexact;
      RND_NEG:  inc = sgn & inexact;
      default:  inc = 1'b0;
    endcase
    away = (rmode_i == RND_NEAR) | ((rmode_i == RND_POS) & ~sgn) |
           ((rmode_i == RND_NEG) & sgn);

    pre_ovf = (de >= EXP_TOP);
    expf    = tiny ? '0 : de[DE-1:0];
    mag     = {1'b0, expf, kept[DM-1:0]} + (DE+DM+1)'(inc);

    flags_o = '0;
    if (&ex) begin
      if (mt != '0) begin
        res_o       = {sgn, {DE{1'b1}}, 1'b1, mt[SM-2 -: DM-1]};
        flags_o.inv = ~mt[SM-1];
      end else begin
        res_o = {sgn, {DE{1'b1}}, {DM{1'b0}}};
      end
    end else if (pre_ovf || (&mag[DE+DM-1:DM])) begin
      res_o       = away ? {sgn, {DE{1'b1}}, {DM{1'b0}}}
                         : {sgn, {(DE-1){1'b1}}, 1'b0, {DM{1'b1}}};
      flags_o.ovf = 1'b1;
      flags_o.nx  = 1'b1;
    end else begin
      res_o       = {sgn, mag[DE+DM-1:0]};
      flags_o.nx  = inexact;
      flags_o.unf = tiny & inexact;
    end
  end

endmodule

// File: rtl/fpn_pack.sv
module fpn_pack
  import fpn_pkg::*;
#(
  parameter int SRC_W = 128,
  parameter int OUT_W = 64
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic             size_i,
  input  rmode_e           rmode_i,
  output logic [OUT_W-1:0] res_o,
  output fpflags_t         flags_o
);

  localparam int NH = OUT_W / 16;
  localparam int NS = OUT_W / 32;

  logic [OUT_W-1:0] res_h;
  logic [OUT_W-1:0] res_s;
  fpflags_t         fl_h [NH];
  fpflags_t         fl_s [NS];

  for (genvar e = 0; e < NH; e++) begin : g_s2h
    fpn_lane_narrow #(.SE(8), .SM(23), .DE(5), .DM(10)) u_lane (
      .src_i  (src_i[32*e +: 32]),
      .rmode_i(rmode_i),
      .res_o  (res_h[16*e +: 16]),
      .flags_o(fl_h[e])
    );
  end

  for (genvar e = 0; e < NS; e++) begin : g_d2s
    fpn_lane_narrow #(.SE(11), .SM(52), .DE(8), .DM(23)) u_lane (
      .src_i  (src_i[64*e +: 64]),
      .rmode_i(rmode_i),
      .res_o  (res_s[32*e +: 32]),
      .flags_o(fl_s[e])
    );
  end

  always_comb begin
    flags_o = '0;
    if (size_i) begin
      res_o = res_s;
      for (int e = 0; e < NS; e++) flags_o = flags_o | fl_s[e];
    end else begin
      res_o = res_h;
      for (int e = 0; e < NH; e++) flags_o = flags_o | fl_h[e];
    end
  end

endmodule

// File: rtl/fpn_narrow_vec.sv
module fpn_narrow_vec
  import fpn_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             size_sel,
  input  logic             half_sel,
  input  logic [1:0]       rmode,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_prev,
  output logic [VEC_W-1:0] dst_out,
  output logic [3:0]       flags_out,
  output logic             done
);

  localparam int HALF_W = VEC_W / 2;

  logic             srst_n;
  logic [HALF_W-1:0] packed_res;
  fpflags_t         lane_fl;
  logic [VEC_W-1:0] dst_d, dst_q;
  fpflags_t         flg_d, flg_q;
  logic             done_d, done_q;

  fpn_rst_sync u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  fpn_pack #(.SRC_W(VEC_W), .OUT_W(HALF_W)) u_pack (
    .src_i  (src_vec),
    .size_i (size_sel),
    .rmode_i(rmode_e'(rmode)),
    .res_o  (packed_res),
    .flags_o(lane_fl)
  );

  always_comb begin
    done_d = in_valid;
    flg_d  = in_valid ? lane_fl : '0;
    dst_d  = dst_q;
    if (in_valid) begin
      if (half_sel) dst_d = {packed_res, dst_prev[HALF_W-1:0]};
      else          dst_d = {{HALF_W{1'b0}}, packed_res};
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dst_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      flg_q  <= flg_d;
      if (in_valid) dst_q <= dst_d;
    end
  end

  assign dst_out   = dst_q;
  assign flags_out = flg_q;
  assign done      = done_q;

  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid |=> done);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> (!done && flags_out == 4'b0000 && $stable(dst_out)));

  // R3
  low_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && !half_sel) |=> dst_out[VEC_W-1:HALF_W] == '0);

  // R4
  low_keep_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && half_sel) |=> dst_out[HALF_W-1:0] == $past(dst_prev[HALF_W-1:0]));

  // R6
  ovf_nx_chk: assert property (@(posedge clk) disable iff (!srst_n)
    flags_out[2] |-> flags_out[0]);

  // R7
  unf_nx_chk: assert property (@(posedge clk) disable iff (!srst_n)
    flags_out[1] |-> flags_out[0]);

endmodule

// File: tb/test_fpn_narrow_vec.sv
module test_fpn_narrow_vec;

  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         size_sel;
  logic         half_sel;
  logic [1:0]   rmode;
  logic [127:0] src_vec;
  logic [127:0] dst_prev;
  logic [127:0] dst_out;
  logic [3:0]   flags_out;
  logic         done;

  int checks = 0;
  int errors = 0;

  localparam logic [127:0] PREV_A = {4{32'hAAAA_AAAA}};

  always #(CLK_P/2) clk = ~clk;

  fpn_narrow_vec i_fpn_narrow_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .size_sel (size_sel),
    .half_sel (half_sel),
    .rmode    (rmode),
    .src_vec  (src_vec),
    .dst_prev (dst_prev),
    .dst_out  (dst_out),
    .flags_out(flags_out),
    .done     (done)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one conversion; returns with the result registered and sampled mid-cycle
  task automatic run_op(input logic sz, input logic hf, input logic [1:0] rm,
                        input logic [127:0] src, input logic [127:0] prev);
    @(negedge clk);
    in_valid = 1'b1; size_sel = sz; half_sel = hf; rmode = rm;
    src_vec = src; dst_prev = prev;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic [63:0] res, input logic [3:0] fl);
    chk({tag, " dst"}, dst_out, {64'h0, res});
    chk({tag, " flags"}, {124'h0, flags_out}, {124'h0, fl});
    chk({tag, " done"}, {127'h0, done}, 128'h1);
  endtask

  task automatic t_reset;
    chk("R11 dst", dst_out, '0);
    chk("R11 flags", {124'h0, flags_out}, '0);
    chk("R11 done", {127'h0, done}, '0);
  endtask

  task automatic t_s2h_basic;
    run_op(1'b0, 1'b0, 2'b00,
           {32'h8000_0000, 32'hC020_0000, 32'h477F_E000, 32'h3F80_0000}, PREV_A);
    expect_res("R1 R3 s2h", 64'h8000_C100_7BFF_3C00, 4'b0000);
  endtask

  task automatic t_high_half;
    run_op(1'b0, 1'b1, 2'b00,
           {32'h8000_0000, 32'hC020_0000, 32'h477F_E000, 32'h3F80_0000}, PREV_A);
    chk("R4 high merge", dst_out, {64'h8000_C100_7BFF_3C00, 64'hAAAA_AAAA_AAAA_AAAA});
  endtask

  task automatic t_d2s_basic;
    run_op(1'b1, 1'b0, 2'b00, {64'hC008_0000_0000_0000, 64'h3FF0_0000_0000_0000}, PREV_A);
    expect_res("R2 d2s", 64'hC040_0000_3F80_0000, 4'b0000);
    run_op(1'b1, 1'b1, 2'b11, {64'hC008_0000_0000_0000, 64'h3FF0_0000_0000_0000}, 128'h1234);
    chk("R2 R4 d2s high", dst_out, {64'hC040_0000_3F80_0000, 64'h1234});
  endtask

  task automatic t_round;
    logic [127:0] src;
    src = {32'h3F80_3000, 32'h3F80_3000, 32'hBF80_1000, 32'h3F80_1000};
    run_op(1'b0, 1'b0, 2'b00, src, '0);
    expect_res("R5 nearest", 64'h3C02_3C02_BC00_3C00, 4'b0001);
    run_op(1'b0, 1'b0, 2'b01, src, '0);
    expect_res("R5 up", 64'h3C02_3C02_BC00_3C01, 4'b0001);
    run_op(1'b0, 1'b0, 2'b10, src, '0);
    expect_res("R5 down", 64'h3C01_3C01_BC01_3C00, 4'b0001);
    run_op(1'b0, 1'b0, 2'b11, src, '0);
    expect_res("R5 zero", 64'h3C01_3C01_BC00_3C00, 4'b0001);
  endtask

  task automatic t_overflow;
    logic [127:0] src;
    src = {32'hC7C3_5000, 32'h47C3_5000, 64'h0};
    run_op(1'b0, 1'b0, 2'b00, src, '0);
    expect_res("R6 near", 64'hFC00_7C00_0000_0000, 4'b0101);
    run_op(1'b0, 1'b0, 2'b11, src, '0);
    expect_res("R6 zero", 64'hFBFF_7BFF_0000_0000, 4'b0101);
    run_op(1'b0, 1'b0, 2'b01, src, '0);
    expect_res("R6 up", 64'hFBFF_7C00_0000_0000, 4'b0101);
    run_op(1'b0, 1'b0, 2'b10, src, '0);
    expect_res("R6 down", 64'hFC00_7BFF_0000_0000, 4'b0101);
    run_op(1'b0, 1'b0, 2'b00, {96'h0, 32'h477F_F000}, '0);
    expect_res("R6 round-carry", 64'h0000_0000_0000_7C00, 4'b0101);
    run_op(1'b1, 1'b0, 2'b00, {64'hFFEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF}, '0);
    expect_res("R6 d2s near", 64'hFF80_0000_7F80_0000, 4'b0101);
    run_op(1'b1, 1'b0, 2'b11, {64'hFFEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF}, '0);
    expect_res("R6 d2s zero", 64'hFF7F_FFFF_7F7F_FFFF, 4'b0101);
  endtask

  task automatic t_subnormal;
    run_op(1'b0, 1'b0, 2'b00,
           {32'h0000_0000, 32'h3800_0000, 32'h3300_0000, 32'h3380_0000}, '0);
    expect_res("R7 near", 64'h0000_0200_0000_0001, 4'b0011);
    run_op(1'b0, 1'b0, 2'b00, {32'h0, 32'h3800_0000, 32'h0, 32'h3380_0000}, '0);
    expect_res("R7 exact tiny", 64'h0000_0200_0000_0001, 4'b0000);
    run_op(1'b0, 1'b0, 2'b01, {32'h0, 32'h0, 32'h3300_0000, 32'h0}, '0);
    expect_res("R7 up", 64'h0000_0000_0001_0000, 4'b0011);
    run_op(1'b0, 1'b0, 2'b10, {32'h8000_0001, 32'h0000_0001, 64'h0}, '0);
    expect_res("R7 src subnormal", 64'h8001_0000_0000_0000, 4'b0011);
  endtask

  task automatic t_nan;
    run_op(1'b0, 1'b0, 2'b00,
           {32'h7FA0_0000, 32'h7F80_0001, 32'hFFC0_0000, 32'h7FC0_0000}, '0);
    expect_res("R8 s2h", 64'h7F00_7E00_FE00_7E00, 4'b1000);
    run_op(1'b1, 1'b0, 2'b00, {64'hFFF8_0000_0000_0000, 64'h7FF8_0000_0000_0000}, '0);
    expect_res("R8 quiet only", 64'hFFC0_0000_7FC0_0000, 4'b0000);
    run_op(1'b1, 1'b0, 2'b00, {64'h7FF4_0000_0000_0000, 64'h7FF8_0000_0000_0000}, '0);
    expect_res("R8 d2s signaling", 64'h7FE0_0000_7FC0_0000, 4'b1000);
  endtask

  task automatic t_special;
    run_op(1'b0, 1'b0, 2'b11,
           {32'h7F80_0000, 32'hFF80_0000, 32'h0000_0000, 32'h8000_0000}, '0);
    expect_res("R9 s2h", 64'h7C00_FC00_0000_8000, 4'b0000);
    run_op(1'b1, 1'b0, 2'b10, {64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000}, '0);
    expect_res("R9 d2s", 64'hFF80_0000_8000_0000, 4'b0000);
  endtask

  task automatic t_timing;
    run_op(1'b0, 1'b0, 2'b00, {96'h0, 32'h3F80_1000}, '0);
    expect_res("R10 pulse", 64'h3C00, 4'b0001);
    src_vec = {4{32'h4000_0000}}; half_sel = 1'b1; dst_prev = '1;
    @(negedge clk);
    chk("R10 done drop", {127'h0, done}, '0);
    chk("R10 flags drop", {124'h0, flags_out}, '0);
    chk("R10 dst hold", dst_out, {64'h0, 64'h3C00});
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; size_sel = 1'b0; half_sel = 1'b0;
    rmode = 2'b00; src_vec = '0; dst_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_s2h_basic;
    t_high_half;
    t_d2s_basic;
    t_round;
    t_overflow;
    t_subnormal;
    t_nan;
    t_special;
    t_timing;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule